// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable 17-bit ratio N. It is built the pulse-swallow way. A prescaler counts either 16 or 17 input clocks per turn. A main counter decides how many prescaler turns make one output cycle, and a swallow counter decides how many of those turns use the longer modulus. Once per N input clocks the block emits a single-clock pulse, which a phase comparator downstream can use. A second output toggles on every pulse, so it runs at half the divided rate and can be watched on a test pin.

A new ratio word is captured whenever the load strobe is high. It is not used at once. The active ratio changes only at the boundary between two output cycles, so the cycle in progress always completes at its old length and the divided frequency steps cleanly. Words below the smallest usable ratio are raised to that minimum.

Top module: `pswd_divider`

## Requirements
- R1: `fdiv_o` is high for exactly one clock, once every N input clocks, where N is the active ratio.
- R2: The ratio word splits into a main count M (bits 16:4) and a swallow count A (bits 3:0), giving N = 16·M + A.
- R3: Within each output cycle the prescaler uses modulus 17 for the first A turns and modulus 16 for the other M−A turns.
- R4: A loaded word below 240 acts as 240.
- R5: Every ratio from 240 up to 131071 (all 17 bits set) is divided exactly.
- R6: A word captured while an output cycle is running leaves that cycle at its old length and takes effect from the next cycle onward.
- R7: `fdiv_half_o` inverts on every clock in which `fdiv_o` is high and holds its value otherwise, so its period is 2·N.
- R8: While `rst_ni` is low both outputs are low and the active ratio is 240. The first pulse after release comes on the 240th rising edge.
- R9: While `load_i` is low, `ratio_i` has no effect on the division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 17 | Ratio word: main count in bits 16:4, swallow count in bits 3:0 |
| load_i | input | 1 | Capture strobe for `ratio_i`, sampled on the rising edge |
| fdiv_o | output | 1 | One-clock pulse per N input clocks |
| fdiv_half_o | output | 1 | Divided output further divided by two |

## Verification
`fdiv_o` is registered. It rises on the Nth rising edge after the previous pulse, or after reset release. A ratio captured by `load_i` governs the output cycle that starts after the next pulse, so the first interval after a load still has the old length, and the interval after that has the new one. The bench counts rising edges in a free-running counter and samples the outputs on falling edges. It measures pulse-to-pulse spacing in whole cycles, which avoids any dependence on the order of events at a clock edge. It scrambles `ratio_i` after each load strobe to show that only the captured word matters.

// File: rtl/pswd_pkg.sv
package pswd_pkg;
    localparam int DEF_RATIO_W  = 17;
    localparam int DEF_SWALLOW_W = 4;
    localparam int DEF_MIN_RATIO = 240;

    typedef enum logic {
        MOD_LO = 1'b0,
        MOD_HI = 1'b1
    } mod_sel_e;
endpackage

// File: rtl/pswd_ratio_reg.sv
module pswd_ratio_reg #(
    parameter int RATIO_W   = pswd_pkg::DEF_RATIO_W,
    parameter int SWALLOW_W = pswd_pkg::DEF_SWALLOW_W,
    parameter int MIN_RATIO = pswd_pkg::DEF_MIN_RATIO
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [RATIO_W-1:0]            ratio_i,
    input  logic                          load_i,
    input  logic                          cycle_end_i,
    output logic [RATIO_W-SWALLOW_W-1:0]  main_o,
    output logic [SWALLOW_W-1:0]          swallow_o
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

    typedef struct packed {
        logic [RATIO_W-1:0] staged;
        logic [RATIO_W-1:0] active;
    } reg_t;

    reg_t st_d, st_q;
    logic [RATIO_W-1:0] word_clamped;

    always_comb begin
        word_clamped = (ratio_i < FLOOR) ? FLOOR : ratio_i;
        st_d = st_q;
        if (load_i) begin
            st_d.staged = word_clamped;
        end
        if (cycle_end_i) begin
            st_d.active = st_q.staged;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.staged <= FLOOR;
            st_q.active <= FLOOR;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_o    = st_q.active[RATIO_W-1:SWALLOW_W];
    assign swallow_o = st_q.active[SWALLOW_W-1:0];

    // R4: the ratio driving the counters never drops under the floor
    a_r4_active_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.active >= FLOOR);

    // R6: the active ratio only moves at an output-cycle boundary
    a_r6_hold_midcycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cycle_end_i |=> $stable(st_q.active));

    // R9: without the strobe the captured word is left alone
    a_r9_staged_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(st_q.staged));
endmodule

// File: rtl/pswd_prescaler.sv
module pswd_prescaler #(
    parameter int SWALLOW_W = pswd_pkg::DEF_SWALLOW_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  pswd_pkg::mod_sel_e mod_i,
    output logic               pre_tc_o
);
    import pswd_pkg::*;

    localparam int PC_W = SWALLOW_W + 1;
    localparam logic [PC_W-1:0] BASE_MOD = PC_W'(1 << SWALLOW_W);

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic [PC_W-1:0] last_val;
    logic            tc;

    always_comb begin
        last_val = (mod_i == MOD_HI) ? BASE_MOD : (BASE_MOD - PC_W'(1));
        tc       = (st_q.cnt == last_val);
        st_d     = st_q;
        st_d.cnt = tc ? '0 : (st_q.cnt + PC_W'(1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_tc_o = tc;

    // R3: the prescaler count never exceeds the long modulus
    a_r3_count_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= BASE_MOD);

    // R3: the seventeenth state is reached only during a long turn
    a_r3_long_only_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == BASE_MOD) |-> (mod_i == MOD_HI));
endmodule

// File: rtl/pswd_swallow.sv
module pswd_swallow #(
    parameter int RATIO_W   = pswd_pkg::DEF_RATIO_W,
    parameter int SWALLOW_W = pswd_pkg::DEF_SWALLOW_W
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          pre_tc_i,
    input  logic [RATIO_W-SWALLOW_W-1:0]  main_i,
    input  logic [SWALLOW_W-1:0]          swallow_i,
    output pswd_pkg::mod_sel_e            mod_o,
    output logic                          cycle_end_o,
    output logic                          fdiv_o,
    output logic                          fdiv_half_o
);
    import pswd_pkg::*;

    localparam int MAIN_W = RATIO_W - SWALLOW_W;

    typedef struct packed {
        logic [MAIN_W-1:0] turns;
        logic              pulse;
        logic              half;
    } sw_t;

    sw_t st_d, st_q;
    logic [MAIN_W-1:0] swallow_ext;
    logic              last_turn;
    logic              end_now;

    always_comb begin
        swallow_ext = {{(MAIN_W-SWALLOW_W){1'b0}}, swallow_i};
        last_turn   = (st_q.turns == (main_i - MAIN_W'(1)));
        end_now     = pre_tc_i && last_turn;
        mod_o       = (st_q.turns < swallow_ext) ? MOD_HI : MOD_LO;

        st_d = st_q;
        if (end_now) begin
            st_d.turns = '0;
        end else if (pre_tc_i) begin
            st_d.turns = st_q.turns + MAIN_W'(1);
        end
        st_d.pulse = end_now;
        st_d.half  = st_q.half ^ end_now;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.turns <= '0;
            st_q.pulse <= 1'b0;
            st_q.half  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cycle_end_o = end_now;
    assign fdiv_o      = st_q.pulse;
    assign fdiv_half_o = st_q.half;

    // R1: an output pulse lasts a single clock
    a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pulse |=> !st_q.pulse);

    // R7: the half-rate output flips exactly when a pulse appears
    a_r7_half_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pulse |-> (st_q.half != $past(st_q.half)));

    // R7: no flip without a pulse
    a_r7_half_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.pulse |-> $stable(st_q.half));

    // R2: the turn count stays inside the main count
    a_r2_turn_span: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.turns < main_i);
endmodule

// File: rtl/pswd_divider.sv
module pswd_divider #(
    parameter int RATIO_W   = pswd_pkg::DEF_RATIO_W,
    parameter int SWALLOW_W = pswd_pkg::DEF_SWALLOW_W,
    parameter int MIN_RATIO = pswd_pkg::DEF_MIN_RATIO
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               load_i,
    output logic               fdiv_o,
    output logic               fdiv_half_o
);
    import pswd_pkg::*;

    localparam int MAIN_W = RATIO_W - SWALLOW_W;

    logic [MAIN_W-1:0]    main_cnt;
    logic [SWALLOW_W-1:0] swallow_cnt;
    mod_sel_e             mod_sel;
    logic                 pre_tc;
    logic                 cycle_end;

    pswd_ratio_reg #(
        .RATIO_W   (RATIO_W),
        .SWALLOW_W (SWALLOW_W),
        .MIN_RATIO (MIN_RATIO)
    ) u_ratio (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ratio_i     (ratio_i),
        .load_i      (load_i),
        .cycle_end_i (cycle_end),
        .main_o      (main_cnt),
        .swallow_o   (swallow_cnt)
    );

    pswd_prescaler #(
        .SWALLOW_W (SWALLOW_W)
    ) u_pre (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mod_i    (mod_sel),
        .pre_tc_o (pre_tc)
    );

    pswd_swallow #(
        .RATIO_W   (RATIO_W),
        .SWALLOW_W (SWALLOW_W)
    ) u_swallow (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pre_tc_i    (pre_tc),
        .main_i      (main_cnt),
        .swallow_i   (swallow_cnt),
        .mod_o       (mod_sel),
        .cycle_end_o (cycle_end),
        .fdiv_o      (fdiv_o),
        .fdiv_half_o (fdiv_half_o)
    );

    // R6: an output pulse follows every cycle boundary one clock later
    a_r6_pulse_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cycle_end |=> fdiv_o);
endmodule

// File: tb/pswd_divider_bench.sv
module pswd_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] ratio = '0;
    logic        load = 1'b0;
    logic        fdiv;
    logic        fdiv_half;

    int unsigned cyc = 0;
    int          n_run = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pswd_divider u_pswd_divider (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .ratio_i     (ratio),
        .load_i      (load),
        .fdiv_o      (fdiv),
        .fdiv_half_o (fdiv_half)
    );

    localparam int NV = 8;
    localparam int unsigned V_WORD [NV] = '{300, 241, 255, 256, 100, 0, 1000, 131071};
    localparam int unsigned V_EXP  [NV] = '{300, 241, 255, 256, 240, 240, 1000, 131071};
    localparam int unsigned WD_LIMIT = 140000;

    task automatic check(input string req, input string what,
                         input int unsigned got, input int unsigned exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // waits for the next pulse on a falling edge, returns the edge count
    task automatic wait_pulse(output int unsigned t, output logic half);
        int unsigned n = 0;
        t = 0;
        half = 1'b0;
        forever begin
            @(negedge clk);
            if (fdiv) begin
                t = cyc;
                half = fdiv_half;
                return;
            end
            n++;
            if (n > WD_LIMIT) begin
                n_run++;
                n_fail++;
                $display("FAIL watchdog: no pulse, actual %0d expected <= %0d", n, WD_LIMIT);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    endtask

    task automatic load_word(input int unsigned w);
        @(negedge clk);
        ratio = 17'(w);
        load  = 1'b1;
        @(negedge clk);
        load  = 1'b0;
        ratio = 17'h0A5F3;  // R9: junk without strobe must not matter
    endtask

    initial begin
        int unsigned t0, t1, t2, old_n, tr;
        logic h0, h1, h2;

        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "fdiv in reset", fdiv, 0);
        check("R8", "fdiv_half in reset", fdiv_half, 0);
        rst_n = 1'b1;
        tr = cyc;
        wait_pulse(t0, h0);
        check("R8", "first pulse after release", t0 - tr, 240);
        check("R7", "half after first pulse", h0, 1);
        @(negedge clk);
        check("R1", "pulse width", fdiv, 0);

        // R9: junk on ratio without strobe, period stays 240
        ratio = 17'd5000;
        wait_pulse(t1, h1);
        wait_pulse(t2, h2);
        check("R9", "period with unstrobed word", t2 - t1, 240);

        // table of ratio vectors
        old_n = 240;
        for (int i = 0; i < NV; i++) begin
            wait_pulse(t0, h0);
            repeat (37) @(negedge clk);
            load_word(V_WORD[i]);
            wait_pulse(t1, h1);
            wait_pulse(t2, h2);
            // R6: cycle in progress keeps its old length
            check("R6", "interval spanning load", t1 - t0, old_n);
            // R1 R2 R3 R4 R5: new period
            check(V_WORD[i] < 240 ? "R4" : (V_WORD[i] == 131071 ? "R5" : "R2/R3"),
                  "period", t2 - t1, V_EXP[i]);
            check("R7", "half toggles per pulse", 32'(h2 != h1), 1);
            old_n = V_EXP[i];
            if (i == NV - 2) begin
                // R8: reset mid-run returns to 240 before the long final vector
                @(negedge clk);
                rst_n = 1'b0;
                @(negedge clk);
                check("R8", "fdiv during mid-run reset", fdiv, 0);
                check("R8", "fdiv_half during mid-run reset", fdiv_half, 0);
                rst_n = 1'b1;
                tr = cyc;
                wait_pulse(t0, h0);
                check("R8", "period after mid-run reset", t0 - tr, 240);
                old_n = 240;
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule